// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block decides which interrupt request a processor core takes next. It watches a set of maskable request lines and one non-maskable request line, and it gives out a one-cycle accept strobe together with the number of the source it chose. Each maskable source has a mask bit and a programmable level, high or low. A global interrupt-enable flag gates every maskable request, and every acceptance clears that flag, so a handler can only be interrupted after software sets the flag again.

The block keeps a small stack that holds the level of each handler in service. A pending request may nest inside the running handler only if its level is at least the level of that handler. Nothing nests inside a non-maskable handler. A request that is refused stays latched. After a handler returns, maskable requests are held back until the core reports that one instruction has completed. When several eligible requests at the same level arrive together, the lowest source index wins.

The core drives the enable set and clear inputs, the return notification and the instruction-complete input. Saving the context, fetching the vector and running the handler all happen outside this block.

Top module: `nest_irq_arbiter`

## Requirements
- R1: After reset, ack_o, ack_nmi_o, ack_idx_o, ie_o and pend_o are all 0, and no handler is in service.
- R2: A maskable request is accepted only while ie_o is 1. Every acceptance clears ie_o at the same edge that raises ack_o, and this overrides an ie_set_i in the same cycle. ie_set_i sets the flag. ie_clr_i clears it, and ie_set_i wins when both are high.
- R3: The choice is made at a clock edge, and ack_o is high for exactly one cycle after that edge. When eligible requests exist, a high-level source (prio_hi_i bit = 1) is chosen over a low-level one. Among sources at the same level, the lowest index wins. ack_idx_o carries the chosen index, and it is 0 whenever no maskable acceptance is shown.
- R4: While a handler is in service and ie_o is 1, a pending, unmasked request whose level is equal to or higher than that handler's level is accepted as a nested interrupt.
- R5: A pending request whose level is lower than the level of the handler in service is not accepted and stays set in pend_o.
- R6: A request on a masked source (mask_i bit = 1) is latched in pend_o but is never accepted while the mask bit is 1.
- R7: ret_i removes the newest handler from the stack. No request is accepted in a cycle where ret_i is high. After a return, no maskable request is accepted until a later cycle with instr_done_i high and ret_i low has been sampled.
- R8: A non-maskable request is accepted regardless of ie_o, the hold that follows a return, and the maskable requests. It is shown as ack_o = 1 with ack_nmi_o = 1 and ack_idx_o = 0.
- R9: While a non-maskable handler is on top of the stack, no request of any kind is accepted.
- R10: When DEPTH handlers are in service, no further request is accepted.
- R11: An accepted source's pend_o bit clears at the acceptance edge, unless a new request on the same source arrives in that cycle, in which case the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NSRC | Maskable request pulses, one bit per source |
| mask_i | input | NSRC | 1 = source excluded from arbitration |
| prio_hi_i | input | NSRC | 1 = source at high programmable level |
| nmi_i | input | 1 | Non-maskable request pulse |
| ie_set_i | input | 1 | Core sets the interrupt-enable flag |
| ie_clr_i | input | 1 | Core clears the interrupt-enable flag |
| ret_i | input | 1 | Core returns from the newest handler |
| instr_done_i | input | 1 | Core completed one instruction |
| ack_o | output | 1 | Accept strobe |
| ack_nmi_o | output | 1 | Accepted request is the non-maskable one |
| ack_idx_o | output | $clog2(NSRC) | Index of the accepted maskable source |
| ie_o | output | 1 | Current interrupt-enable flag |
| pend_o | output | NSRC | Latched maskable request flags |

## Verification
A corrupted entry in the level stack shows up as a nesting decision that goes the wrong way. A request at the wrong level is accepted, or an eligible one is refused, within a cycle of the next pending request. A wrong stack depth appears as an accept past the DEPTH limit, or as a refused accept once all handlers have returned. A hold flag that is stuck or cleared too early shows up as an ack_o in the cycle right after a return, or as a deferred request that never fires. The bench's cycle model checks ack_o, ack_nmi_o, ack_idx_o, ie_o and pend_o on every cycle, so each such fault is reported at the first edge where it changes a port.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  // Level ordering is behaviour: higher encoding may nest over lower.
  typedef enum logic [1:0] {
    LV_LOW  = 2'd0,
    LV_HIGH = 2'd1,
    LV_NMI  = 2'd2
  } lvl_t;

  function automatic lvl_t level_of(input logic hi);
    return hi ? LV_HIGH : LV_LOW;
  endfunction

  // A candidate may nest over the active handler when its level is not lower.
  function automatic logic lvl_admits(input lvl_t cand, input lvl_t active);
    return cand >= active;
  endfunction
endpackage

// File: rtl/nirq_pick.sv
module nirq_pick #(
  parameter int NSRC = 8,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] vec,
  output logic            found,
  output logic [IDXW-1:0] idx,
  output logic [NSRC-1:0] grant
);
  function automatic logic [IDXW-1:0] lowest_set(input logic [NSRC-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDXW'(i);
    end
    return r;
  endfunction

  assign found = |vec;
  assign idx   = lowest_set(vec);
  assign grant = vec & (~vec + NSRC'(1));
endmodule

// File: rtl/nirq_lvl_stack.sv
module nirq_lvl_stack
  import nirq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int SPW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  input  lvl_t           lvl_in,
  output lvl_t           top,
  output logic           empty,
  output logic           full,
  output logic [SPW-1:0] depth
);
  lvl_t           mem [DEPTH];
  logic [SPW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sp_q <= '0;
    else if (push) sp_q <= sp_q + SPW'(1);
    else if (pop) sp_q <= sp_q - SPW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) mem[g] <= LV_LOW;
      else if (push && sp_q == SPW'(g)) mem[g] <= lvl_in;
    end
  end

  always_comb begin
    top = LV_LOW;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp_q == SPW'(i + 1)) top = mem[i];
    end
  end

  assign empty = (sp_q == '0);
  assign full  = (sp_q == SPW'(DEPTH));
  assign depth = sp_q;

  a_r10_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r7_pop_only_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r7_push_pop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= SPW'(DEPTH));
endmodule

// File: rtl/nirq_gate.sv
module nirq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic ie_set,
  input  logic ie_clr,
  input  logic ret,
  input  logic instr_done,
  output logic ie_q,
  output logic hold_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (accept) ie_q <= 1'b0;
      else if (ie_set) ie_q <= 1'b1;
      else if (ie_clr) ie_q <= 1'b0;
      if (ret) hold_q <= 1'b1;
      else if (instr_done) hold_q <= 1'b0;
    end
  end

  a_r2_accept_drops_ie: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ie_q);
  a_r7_return_sets_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ret |=> hold_q);
endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter
  import nirq_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int DEPTH = 4,
  localparam int IDXW = $clog2(NSRC),
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic [NSRC-1:0] prio_hi_i,
  input  logic            nmi_i,
  input  logic            ie_set_i,
  input  logic            ie_clr_i,
  input  logic            ret_i,
  input  logic            instr_done_i,
  output logic            ack_o,
  output logic            ack_nmi_o,
  output logic [IDXW-1:0] ack_idx_o,
  output logic            ie_o,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q;
  logic            nmi_pend_q;
  logic            ack_q, ack_nmi_q;
  logic [IDXW-1:0] idx_q;

  // Candidate split by programmable level; each half picks lowest index.
  logic [NSRC-1:0] elig, lvl_vec [2], lvl_grant [2];
  logic            lvl_found [2];
  logic [IDXW-1:0] lvl_idx [2];

  assign elig = pend_q & ~mask_i;

  for (genvar l = 0; l < 2; l++) begin : g_lvl
    assign lvl_vec[l] = (l == 1) ? (elig & prio_hi_i) : (elig & ~prio_hi_i);
    nirq_pick #(.NSRC(NSRC)) u_pick (
      .vec  (lvl_vec[l]),
      .found(lvl_found[l]),
      .idx  (lvl_idx[l]),
      .grant(lvl_grant[l])
    );
  end

  logic            best_found;
  logic [IDXW-1:0] best_idx;
  logic [NSRC-1:0] best_grant;
  lvl_t            best_lvl;

  assign best_found = lvl_found[1] | lvl_found[0];
  assign best_idx   = lvl_found[1] ? lvl_idx[1] : lvl_idx[0];
  assign best_grant = lvl_found[1] ? lvl_grant[1] : lvl_grant[0];
  assign best_lvl   = level_of(lvl_found[1]);

  // In-service level stack.
  lvl_t           top_lvl;
  logic           stk_empty, stk_full;
  logic [SPW-1:0] stk_depth;
  logic           ie_q, hold_q;

  wire in_nmi    = !stk_empty && (top_lvl == LV_NMI);
  wire can_take  = !in_nmi && !stk_full && !ret_i;
  wire nest_ok   = stk_empty || lvl_admits(best_lvl, top_lvl);
  wire fire_nmi  = nmi_pend_q && can_take;
  wire fire_msk  = !fire_nmi && can_take && best_found && ie_q && !hold_q && nest_ok;
  wire fire_any  = fire_nmi || fire_msk;
  wire do_pop    = ret_i && !stk_empty;
  wire lvl_t push_lvl = fire_nmi ? LV_NMI : best_lvl;

  nirq_lvl_stack #(.DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fire_any),
    .pop   (do_pop),
    .lvl_in(push_lvl),
    .top   (top_lvl),
    .empty (stk_empty),
    .full  (stk_full),
    .depth (stk_depth)
  );

  nirq_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (fire_any),
    .ie_set    (ie_set_i),
    .ie_clr    (ie_clr_i),
    .ret       (ret_i),
    .instr_done(instr_done_i),
    .ie_q      (ie_q),
    .hold_q    (hold_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      nmi_pend_q <= 1'b0;
      ack_q      <= 1'b0;
      ack_nmi_q  <= 1'b0;
      idx_q      <= '0;
    end else begin
      pend_q     <= (pend_q & ~(fire_msk ? best_grant : '0)) | req_i;
      nmi_pend_q <= (nmi_pend_q & ~fire_nmi) | nmi_i;
      ack_q      <= fire_any;
      ack_nmi_q  <= fire_nmi;
      idx_q      <= fire_msk ? best_idx : '0;
    end
  end

  assign ack_o     = ack_q;
  assign ack_nmi_o = ack_nmi_q;
  assign ack_idx_o = idx_q;
  assign ie_o      = ie_q;
  assign pend_o    = pend_q;

  a_r2_masked_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !ack_nmi_o) |-> $past(ie_o));
  a_r2_ack_sees_ie_low: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !ie_o);
  a_r9_no_nest_in_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    (in_nmi && !ret_i) |=> !ack_o);
  a_r7_hold_blocks_masked: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> !(ack_o && !ack_nmi_o));
  a_r7_no_accept_on_return: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |=> !ack_o);
  a_r3_grant_is_index: assert property (@(posedge clk) disable iff (!rst_n)
    best_found |-> (best_grant[best_idx] && $onehot(best_grant)));
  a_r8_nmi_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ack_nmi_o |-> (ack_o && ack_idx_o == '0));
  a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !ack_nmi_o) |=> !(ack_o && !ack_nmi_o));
endmodule

// File: tb/sim_nest_irq_arbiter.sv
`timescale 1ns/1ps
module sim_nest_irq_arbiter;
  localparam int NSRC  = 8;
  localparam int DEPTH = 4;
  localparam int IDXW  = $clog2(NSRC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] req_i = '0, mask_i = '0, prio_hi_i = '0;
  logic nmi_i = 0, ie_set_i = 0, ie_clr_i = 0, ret_i = 0, instr_done_i = 0;
  logic ack_o, ack_nmi_o, ie_o;
  logic [IDXW-1:0] ack_idx_o;
  logic [NSRC-1:0] pend_o;

  always #2 clk = ~clk;

  nest_irq_arbiter #(.NSRC(NSRC), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i),
    .prio_hi_i(prio_hi_i), .nmi_i(nmi_i), .ie_set_i(ie_set_i),
    .ie_clr_i(ie_clr_i), .ret_i(ret_i), .instr_done_i(instr_done_i),
    .ack_o(ack_o), .ack_nmi_o(ack_nmi_o), .ack_idx_o(ack_idx_o),
    .ie_o(ie_o), .pend_o(pend_o)
  );

  int checks = 0, errors = 0, cyc_cnt = 0;

  // Reference model state (levels: 0 low, 1 high, 2 non-maskable)
  logic [NSRC-1:0] m_pend;
  logic m_nmi, m_ie, m_hold;
  int m_stk [DEPTH];
  int m_sp;
  logic e_ack, e_nmi;
  int e_idx;

  task automatic model_reset();
    m_pend = '0; m_nmi = 0; m_ie = 0; m_hold = 0; m_sp = 0;
    e_ack = 0; e_nmi = 0; e_idx = 0;
  endtask

  task automatic model_step();
    bit in_nmi, room, fn, fm;
    int best, blvl;
    in_nmi = (m_sp > 0) && (m_stk[m_sp-1] == 2);
    room = m_sp < DEPTH;
    fn = m_nmi && !in_nmi && room && !ret_i;
    best = -1; blvl = 0;
    for (int lv = 1; lv >= 0; lv--)
      for (int i = 0; i < NSRC; i++)
        if (best < 0 && m_pend[i] && !mask_i[i] && (int'(prio_hi_i[i]) == lv)) begin
          best = i; blvl = lv;
        end
    fm = !fn && best >= 0 && m_ie && !m_hold && !in_nmi && room && !ret_i &&
         (m_sp == 0 || blvl >= m_stk[m_sp-1]);
    e_ack = fn || fm; e_nmi = fn; e_idx = fm ? best : 0;
    if (fm) m_pend[best] = 1'b0;
    m_pend = m_pend | req_i;
    if (fn) m_nmi = 0;
    if (nmi_i) m_nmi = 1;
    if (fn || fm) m_ie = 0; else if (ie_set_i) m_ie = 1; else if (ie_clr_i) m_ie = 0;
    if (ret_i) m_hold = 1; else if (instr_done_i) m_hold = 0;
    if (ret_i && m_sp > 0) m_sp--;
    else if (fn) begin m_stk[m_sp] = 2; m_sp++; end
    else if (fm) begin m_stk[m_sp] = blvl; m_sp++; end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "ack_o", int'(ack_o), int'(e_ack));
    chk(tag, "ack_nmi_o", int'(ack_nmi_o), int'(e_nmi));
    chk(tag, "ack_idx_o", int'(ack_idx_o), e_idx);
    chk(tag, "ie_o", int'(ie_o), int'(m_ie));
    chk(tag, "pend_o", int'(pend_o), int'(m_pend));
  endtask

  task automatic cyc(string tag, int n);
    for (int k = 0; k < n; k++) begin
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare(tag);
    end
  endtask

  task automatic clr_in();
    req_i = '0; nmi_i = 0; ie_set_i = 0; ie_clr_i = 0; ret_i = 0; instr_done_i = 0;
  endtask

  task automatic drain(string tag);
    clr_in();
    while (m_sp > 0) begin
      ret_i = 1; cyc(tag, 1); ret_i = 0;
    end
    instr_done_i = 1; cyc(tag, 1); instr_done_i = 0;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d expected completion", cyc_cnt);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F3A_5C07));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1");
    cyc("R1", 2);

    // R3: sources 3,5 high, 2 low; requests latched while IE is 0 (R2)
    prio_hi_i = 8'b0010_1000;
    req_i = 8'b0010_1100; cyc("R2", 1); req_i = '0;
    cyc("R2", 2);
    ie_set_i = 1; cyc("R2", 1); ie_set_i = 0;
    cyc("R3", 2);
    // R4: IE set again, high source 5 nests inside high handler
    ie_set_i = 1; cyc("R4", 1); ie_set_i = 0;
    cyc("R4", 2);
    // R5: low source 2 refused inside high handler
    ie_set_i = 1; cyc("R5", 1); ie_set_i = 0;
    cyc("R5", 4);
    // R7: returns, then hold until an instruction completes
    ret_i = 1; cyc("R7", 1); ret_i = 0;
    cyc("R7", 2);
    ret_i = 1; cyc("R7", 1); ret_i = 0;
    cyc("R7", 3);
    instr_done_i = 1; cyc("R7", 1); instr_done_i = 0;
    cyc("R7", 3);
    drain("R7");
    // R6: masked source latched but never taken
    mask_i = 8'b0000_0010; req_i = 8'b0000_0010; ie_set_i = 1;
    cyc("R6", 1); clr_in();
    cyc("R6", 4);
    // R8: non-maskable with IE low
    ie_clr_i = 1; cyc("R8", 1); ie_clr_i = 0;
    nmi_i = 1; cyc("R8", 1); nmi_i = 0;
    cyc("R8", 2);
    // R9: nothing nests in non-maskable handler
    nmi_i = 1; req_i = 8'b0001_0000; ie_set_i = 1; mask_i = '0;
    cyc("R9", 1); clr_in();
    cyc("R9", 4);
    ret_i = 1; cyc("R8", 1); ret_i = 0;
    cyc("R8", 3);
    drain("R8");
    cyc("R6", 3);
    drain("R6");
    // R10: fill the stack with high-level nests
    prio_hi_i = '1;
    for (int d = 0; d < DEPTH + 2; d++) begin
      req_i = 8'b0100_0000; ie_set_i = 1; cyc("R10", 1); clr_in();
      cyc("R10", 2);
    end
    drain("R10");
    // R11: request on a source in its own acceptance cycle keeps it pending
    ie_set_i = 1; cyc("R11", 1); ie_set_i = 0;
    req_i = 8'b0000_0001; cyc("R11", 2); req_i = '0;
    cyc("R11", 2);
    drain("R11");

    // Constrained random phase
    for (int n = 0; n < 4000; n++) begin
      if (n % 64 == 0) begin
        mask_i = NSRC'($urandom & $urandom & $urandom);
        prio_hi_i = NSRC'($urandom);
      end
      req_i = ($urandom % 6 == 0) ? NSRC'(1 << ($urandom % NSRC)) : '0;
      nmi_i = ($urandom % 97 == 0);
      ie_set_i = ($urandom % 4 == 0);
      ie_clr_i = ($urandom % 19 == 0);
      ret_i = (m_sp > 0) && ($urandom % 5 == 0);
      instr_done_i = ($urandom % 3 == 0);
      cyc("R3 R4 R5 R11 random", 1);
    end
    clr_in();
    cyc("R2", 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule